// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor system into one of two low-power states and brings it back out. Software issues a single power-save request with a mode operand. Idle stops only the CPU clock and leaves the peripherals running. Sleep also stops the main oscillator, the peripheral clock and the clock monitor. If the watchdog is enabled, the block clears it on entry to sleep and keeps the low-power RC clock running for it.

The system wakes from either state on an interrupt that is both pending and enabled. It also wakes on a watchdog time-out while the watchdog is enabled, or on reset. After sleep the main oscillator restarts first, and the CPU clock stays gated until the oscillator reports ready or a fixed stabilisation count runs out. The clock-source selection that was active at entry is held throughout, so the system resumes on the same source. Two sticky flags record which state was exited.

Top module: `lp_seq`

## Requirements
- R1: In the running state, a request with mode operand 0 enters sleep and operand 1 enters idle. Any other operand value is ignored, and the CPU clock enable stays high.
- R2: In sleep, the CPU clock enable, peripheral clock enable, main oscillator enable and clock-monitor enable are all low.
- R3: In idle, the CPU clock enable is low while the peripheral clock, main oscillator and clock monitor enables stay high.
- R4: Either state is left when some bit is set in both the pending and enable vectors, or when the watchdog time-out is high while the watchdog is enabled. A pending source whose enable bit is 0 has no effect. A time-out while the watchdog is disabled has no effect.
- R5: On sleep entry with the watchdog enabled, the watchdog clear output is high for exactly one cycle, the first cycle of sleep. It stays low on sleep entry with the watchdog disabled, and it stays low on idle entry.
- R6: The low-power RC enable equals the watchdog enable during sleep. Outside sleep it is high when the watchdog is enabled or the retained source equals LPRC_SRC (default 5).
- R7: After a sleep wake, the main oscillator enable is high while the CPU clock, peripheral clock and monitor enables stay low. This lasts until the oscillator ready input is seen, or for STAB_CYC (default 16) cycles when ready never comes.
- R8: A wake from idle restores the CPU clock enable on the next cycle.
- R9: The retained clock-source output follows the source input, one cycle late, only while running. Outside the running state it holds the value taken in the cycle of the request, so the system resumes on that source.
- R10: The sleep-exit and idle-exit flags are set when the matching state is left and stay set. The clear input clears both.
- R11: An asynchronous active-low reset returns the block to running at any time. In reset all clock enables are high, the flags and the watchdog clear are low, and the retained source is SRC_RST (default 0).
- R12: A power-save request is ignored while the block is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrsav_req_i | input | 1 | Power-save request strobe |
| pwrsav_mode_i | input | MODE_W | Mode operand: 0 sleep, 1 idle |
| irq_pend_i | input | NUM_IRQ | Per-source interrupt pending |
| irq_en_i | input | NUM_IRQ | Per-source interrupt enable |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog time-out |
| osc_rdy_i | input | 1 | Main oscillator ready |
| clk_src_i | input | SRC_W | Clock source currently selected |
| stat_clr_i | input | 1 | Software clear of both exit flags |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| lprc_en_o | output | 1 | Low-power RC oscillator enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| clk_mon_en_o | output | 1 | Fail-safe clock monitor enable |
| clk_src_o | output | SRC_W | Retained clock-source select |
| slept_flag_o | output | 1 | Sticky: sleep was exited |
| idled_flag_o | output | 1 | Sticky: idle was exited |

## Verification
The bench probes the stabilisation window without an oscillator ready. It counts the gated cycles, because a counter off by one would release the CPU after 15 or 17 cycles instead of 16. It changes the source input during sleep and checks the output through the wake sequence; a design that kept tracking the input would resume on the wrong oscillator. It drives masked interrupts, a time-out with the watchdog disabled, unknown mode operands and requests issued while idle, any of which a loose decode would turn into a spurious wake or entry. It checks that the watchdog clear is a single cycle, and that the RC enable drops in sleep when the watchdog is off, even with the RC as the selected source.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  typedef enum logic [1:0] {
    LP_RUN   = 2'd0,
    LP_IDLE  = 2'd1,
    LP_SLEEP = 2'd2,
    LP_STAB  = 2'd3
  } lp_state_e;

  localparam int unsigned MODE_SLEEP = 0;
  localparam int unsigned MODE_IDLE  = 1;
endpackage

// File: rtl/lp_wake_detect.sv
module lp_wake_detect #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wdt_en_i,
  input  logic               wdt_timeout_i,
  output logic               wake_o
);
  logic [NUM_IRQ-1:0] hit;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign hit[i] = irq_pend_i[i] & irq_en_i[i];
  end

  assign wake_o = (|hit) | (wdt_en_i & wdt_timeout_i);
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_seq_pkg::*;
#(
  parameter int MODE_W   = 4,
  parameter int STAB_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wake_i,
  input  logic              osc_rdy_i,
  input  logic              wdt_en_i,
  output lp_state_e         state_o,
  output logic              wdt_clr_o,
  output logic              sleep_exit_o,
  output logic              idle_exit_o
);
  localparam int CNT_W = (STAB_CYC > 2) ? $clog2(STAB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYC - 1);

  lp_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_q, clr_d;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    clr_d        = 1'b0;
    sleep_exit_o = 1'b0;
    idle_exit_o  = 1'b0;
    unique case (state_q)
      LP_RUN: begin
        if (req_i && mode_i == MODE_W'(MODE_SLEEP)) begin
          state_d = LP_SLEEP;
          clr_d   = wdt_en_i;
        end else if (req_i && mode_i == MODE_W'(MODE_IDLE)) begin
          state_d = LP_IDLE;
        end
      end
      LP_IDLE: begin
        if (wake_i) begin
          state_d     = LP_RUN;
          idle_exit_o = 1'b1;
        end
      end
      LP_SLEEP: begin
        if (wake_i) begin
          state_d      = LP_STAB;
          cnt_d        = '0;
          sleep_exit_o = 1'b1;
        end
      end
      LP_STAB: begin
        if (osc_rdy_i || cnt_q == CNT_LAST) state_d = LP_RUN;
        else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = LP_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LP_RUN;
      cnt_q   <= '0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      clr_q   <= clr_d;
    end
  end

  assign state_o   = state_q;
  assign wdt_clr_o = clr_q;
endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_seq_pkg::*;
#(
  parameter int SRC_W    = 3,
  parameter int LPRC_SRC = 5,
  parameter int SRC_RST  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lp_state_e        state_i,
  input  logic             wdt_en_i,
  input  logic [SRC_W-1:0] clk_src_i,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             main_osc_en_o,
  output logic             lprc_en_o,
  output logic             clk_mon_en_o,
  output logic [SRC_W-1:0] clk_src_o
);
  logic [SRC_W-1:0] src_q;
  logic             running, sleeping, osc_stable;

  assign running    = (state_i == LP_RUN);
  assign sleeping   = (state_i == LP_SLEEP);
  assign osc_stable = running || (state_i == LP_IDLE);

  // source only tracks software while the CPU runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      src_q <= SRC_W'(SRC_RST);
    else if (running) src_q <= clk_src_i;
  end

  assign cpu_clk_en_o    = running;
  assign periph_clk_en_o = osc_stable;
  assign clk_mon_en_o    = osc_stable;
  assign main_osc_en_o   = !sleeping;
  assign lprc_en_o       = sleeping ? wdt_en_i
                                    : (wdt_en_i || src_q == SRC_W'(LPRC_SRC));
  assign clk_src_o       = src_q;
endmodule

// File: rtl/lp_status.sv
module lp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_exit_i,
  input  logic idle_exit_i,
  input  logic clr_i,
  output logic slept_o,
  output logic idled_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slept_o <= 1'b0;
      idled_o <= 1'b0;
    end else begin
      slept_o <= sleep_exit_i | (slept_o & !clr_i);
      idled_o <= idle_exit_i  | (idled_o & !clr_i);
    end
  end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
  import lp_seq_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int MODE_W   = 4,
  parameter int SRC_W    = 3,
  parameter int LPRC_SRC = 5,
  parameter int SRC_RST  = 0,
  parameter int STAB_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwrsav_req_i,
  input  logic [MODE_W-1:0]  pwrsav_mode_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               wdt_en_i,
  input  logic               wdt_timeout_i,
  input  logic               osc_rdy_i,
  input  logic [SRC_W-1:0]   clk_src_i,
  input  logic               stat_clr_i,
  output logic               cpu_clk_en_o,
  output logic               periph_clk_en_o,
  output logic               main_osc_en_o,
  output logic               lprc_en_o,
  output logic               wdt_clr_o,
  output logic               clk_mon_en_o,
  output logic [SRC_W-1:0]   clk_src_o,
  output logic               slept_flag_o,
  output logic               idled_flag_o
);
  lp_state_e state;
  logic      wake, sleep_exit, idle_exit;

  lp_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_pend_i    (irq_pend_i),
    .irq_en_i      (irq_en_i),
    .wdt_en_i      (wdt_en_i),
    .wdt_timeout_i (wdt_timeout_i),
    .wake_o        (wake)
  );

  lp_fsm #(.MODE_W(MODE_W), .STAB_CYC(STAB_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (pwrsav_req_i),
    .mode_i       (pwrsav_mode_i),
    .wake_i       (wake),
    .osc_rdy_i    (osc_rdy_i),
    .wdt_en_i     (wdt_en_i),
    .state_o      (state),
    .wdt_clr_o    (wdt_clr_o),
    .sleep_exit_o (sleep_exit),
    .idle_exit_o  (idle_exit)
  );

  lp_clk_ctrl #(.SRC_W(SRC_W), .LPRC_SRC(LPRC_SRC), .SRC_RST(SRC_RST)) u_clk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .state_i         (state),
    .wdt_en_i        (wdt_en_i),
    .clk_src_i       (clk_src_i),
    .cpu_clk_en_o    (cpu_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .main_osc_en_o   (main_osc_en_o),
    .lprc_en_o       (lprc_en_o),
    .clk_mon_en_o    (clk_mon_en_o),
    .clk_src_o       (clk_src_o)
  );

  lp_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_exit_i (sleep_exit),
    .idle_exit_i  (idle_exit),
    .clr_i        (stat_clr_i),
    .slept_o      (slept_flag_o),
    .idled_o      (idled_flag_o)
  );
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
  parameter int NUM_IRQ = 8,
  parameter int MODE_W  = 4,
  parameter int SRC_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pwrsav_req_i,
  input logic [MODE_W-1:0]  pwrsav_mode_i,
  input logic [NUM_IRQ-1:0] irq_pend_i,
  input logic [NUM_IRQ-1:0] irq_en_i,
  input logic               wdt_en_i,
  input logic               osc_rdy_i,
  input logic               cpu_clk_en_o,
  input logic               periph_clk_en_o,
  input logic               main_osc_en_o,
  input logic               lprc_en_o,
  input logic               wdt_clr_o,
  input logic               clk_mon_en_o,
  input logic [SRC_W-1:0]   clk_src_o,
  input logic               slept_flag_o
);
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && pwrsav_req_i && pwrsav_mode_i == '0 |=> !main_osc_en_o); // R1

  AST_BAD_MODE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && pwrsav_req_i && pwrsav_mode_i > MODE_W'(1) |=> cpu_clk_en_o); // R1

  AST_SLEEP_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_osc_en_o |-> !cpu_clk_en_o && !periph_clk_en_o && !clk_mon_en_o); // R2

  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o && pwrsav_req_i && pwrsav_mode_i == MODE_W'(1)
    |=> !cpu_clk_en_o && periph_clk_en_o && main_osc_en_o && clk_mon_en_o); // R3

  AST_WDT_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |=> !wdt_clr_o); // R5

  AST_WDT_CLR_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_o |-> !main_osc_en_o); // R5

  AST_LPRC_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_osc_en_o |-> lprc_en_o == wdt_en_i); // R6

  AST_STAB_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_osc_en_o && !periph_clk_en_o && osc_rdy_i |=> cpu_clk_en_o); // R7

  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_clk_en_o && !cpu_clk_en_o && (|(irq_pend_i & irq_en_i)) |=> cpu_clk_en_o); // R8

  AST_SRC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cpu_clk_en_o) |-> $stable(clk_src_o)); // R9

  AST_SLEPT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slept_flag_o) |-> $past(!main_osc_en_o)); // R10
endmodule

bind lp_seq lp_seq_chk #(.NUM_IRQ(NUM_IRQ), .MODE_W(MODE_W), .SRC_W(SRC_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .pwrsav_req_i    (pwrsav_req_i),
  .pwrsav_mode_i   (pwrsav_mode_i),
  .irq_pend_i      (irq_pend_i),
  .irq_en_i        (irq_en_i),
  .wdt_en_i        (wdt_en_i),
  .osc_rdy_i       (osc_rdy_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .main_osc_en_o   (main_osc_en_o),
  .lprc_en_o       (lprc_en_o),
  .wdt_clr_o       (wdt_clr_o),
  .clk_mon_en_o    (clk_mon_en_o),
  .clk_src_o       (clk_src_o),
  .slept_flag_o    (slept_flag_o)
);

// File: tb/test_lp_seq.sv
module test_lp_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] pend = '0, en = '0;
  logic       wdt_en = 1'b0, wdt_to = 1'b0, osc_rdy = 1'b0, stat_clr = 1'b0;
  logic [2:0] src_in = '0;
  logic       cpu, periph, osc, lprc, wclr, mon, slept, idled;
  logic [2:0] src_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lp_seq i_lp_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwrsav_req_i(req), .pwrsav_mode_i(mode),
    .irq_pend_i(pend), .irq_en_i(en), .wdt_en_i(wdt_en), .wdt_timeout_i(wdt_to),
    .osc_rdy_i(osc_rdy), .clk_src_i(src_in), .stat_clr_i(stat_clr),
    .cpu_clk_en_o(cpu), .periph_clk_en_o(periph), .main_osc_en_o(osc),
    .lprc_en_o(lprc), .wdt_clr_o(wclr), .clk_mon_en_o(mon), .clk_src_o(src_out),
    .slept_flag_o(slept), .idled_flag_o(idled)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic request(logic [3:0] m);
    req = 1'b1; mode = m;
    step();
    req = 1'b0; mode = '0;
  endtask

  task automatic t_reset();
    chk("R11 cpu in reset", cpu, 1);
    chk("R11 osc in reset", osc, 1);
    chk("R11 periph/mon in reset", {periph, mon}, 2'b11);
    chk("R11 flags/wclr in reset", {slept, idled, wclr}, 3'b000);
    chk("R11 src reset value", src_out, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_bad_mode();
    request(4'd2);
    chk("R1 operand 2 ignored", {cpu, periph, osc}, 3'b111);
    request(4'd15);
    chk("R1 operand 15 ignored", {cpu, periph, osc}, 3'b111);
  endtask

  task automatic t_idle();
    wdt_en = 1'b1;
    request(4'd1);
    chk("R3 idle enables cpu/periph/osc/mon", {cpu, periph, osc, mon}, 4'b0111);
    chk("R5 no clear on idle", wclr, 0);
    request(4'd0);
    chk("R12 request in idle ignored", {cpu, periph, osc}, 3'b011);
    pend = 8'h04; en = 8'h00;
    step();
    chk("R4 masked source no wake", {cpu, periph}, 2'b01);
    en = 8'h04;
    step();
    chk("R8 idle wake next cycle", cpu, 1);
    chk("R10 idle flag set", {idled, slept}, 2'b10);
    pend = '0; en = '0;
    step();
  endtask

  task automatic t_sleep_wdt();
    int n;
    src_in = 3'd3; wdt_en = 1'b1;
    step();
    request(4'd0);
    chk("R2 sleep gates", {cpu, periph, osc, mon}, 4'b0000);
    chk("R5 clear pulse first sleep cycle", wclr, 1);
    chk("R6 lprc on in sleep with wdt", lprc, 1);
    src_in = 3'd6;
    step();
    chk("R5 clear pulse one cycle", wclr, 0);
    chk("R9 src held in sleep", src_out, 3);
    wdt_to = 1'b1;
    step();
    wdt_to = 1'b0;
    chk("R4 R7 wdt wake osc on cpu off", {osc, cpu, periph, mon}, 4'b1000);
    chk("R10 sleep flag set", slept, 1);
    chk("R10 idle flag sticky", idled, 1);
    n = 1;
    while (!cpu && n < 40) begin
      step();
      if (!cpu) n++;
    end
    chk("R7 stabilisation cycle count", n, 16);
    chk("R9 src restored at wake", src_out, 3);
    step();
    chk("R9 src follows when running", src_out, 6);
  endtask

  task automatic t_sleep_nowdt();
    wdt_en = 1'b0; src_in = 3'd5;
    step(); step();
    chk("R6 lprc on as running source", lprc, 1);
    stat_clr = 1'b1;
    step();
    stat_clr = 1'b0;
    chk("R10 clear both flags", {slept, idled}, 2'b00);
    request(4'd0);
    chk("R5 no clear without wdt", wclr, 0);
    chk("R6 lprc off in sleep without wdt", lprc, 0);
    wdt_to = 1'b1;
    step();
    wdt_to = 1'b0;
    chk("R4 timeout with wdt off ignored", {osc, slept}, 2'b00);
    osc_rdy = 1'b1; pend = 8'h01; en = 8'h81;
    step();
    pend = '0;
    chk("R7 first wake cycle gated", {osc, cpu}, 2'b10);
    step();
    chk("R7 ready releases cpu", {cpu, periph, mon}, 3'b111);
    osc_rdy = 1'b0; en = '0;
  endtask

  task automatic t_reset_sleep();
    wdt_en = 1'b1;
    request(4'd0);
    chk("R2 in sleep before reset", osc, 0);
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async reset leaves sleep", {cpu, osc, slept, idled}, 4'b1100);
    step();
    rst_n = 1'b1;
    step();
    chk("R11 running after reset", cpu, 1);
  endtask

  initial begin
    step(); step();
    t_reset();
    t_bad_mode();
    t_idle();
    t_sleep_wdt();
    t_sleep_nowdt();
    t_reset_sleep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule